// File: doc/BRIEF.md
# Multi-Sector Transfer Sequencer

This block runs one disk transfer command from start to finish. A command names an operation (read, verify, write or scan), the address of a small control block held in memory, and a starting data address. The sequencer reads the wanted cylinder, the first sector and the sector count out of that control block. It then walks a run of fixed-size sectors and moves each byte between the data area in memory and a sector storage port. At the end it stores its progress back into the control block.

Logical sector numbers on a cylinder are not contiguous. The first head holds 0 to 23 and the second holds 32 to 55, and the sequencer skips the unused numbers as it goes. It refuses to touch the media when the arm is on the wrong cylinder. It stops at the last sector of the cylinder if work is still left. A scan compares media bytes against memory bytes and can stop at the first sector whose result matches a requested condition. Memory and sector storage are both byte-wide request ports with a valid/ready handshake.

Top module: `xfer_seq`

## Requirements
- R1: A start in the idle state latches the operation, the scan condition, the control-block address and the data address. The block then reads memory at control offsets 1 (cylinder), 2 (sector byte) and 3 (count). The first logical sector is bits 7:2 of the sector byte, and the run covers count+1 sectors unless it stops early. Operation codes are 0 read, 1 verify, 2 write and 3 scan.
- R2: Sectors are visited in logical order, and 23 is followed by 32. Logical numbers up to 23 map to the same physical index and numbers from 32 map to the number minus 8. Byte k of a sector is reached at sector address armCyl*48*SECT_BYTES + physical*SECT_BYTES + k, with bytes in ascending order.
- R3: A read copies each sector byte to memory at consecutive data addresses. Afterwards dataAddr points one past the last byte moved, modulo 65536.
- R4: A verify reads every sector byte but makes no memory write except the two write-back bytes, and dataAddr stays at its start value.
- R5: A write fetches memory bytes from consecutive data addresses and writes each to the sector port in the same order. dataAddr advances as for a read.
- R6: If the cylinder in the control block differs from armCyl, no sector transfer takes place. errFlags bit 11 (0x0800) is set for read, verify or scan, or bit 10 (0x0400) for write. The write-back then stores the starting sector and the unchanged count.
- R7: If logical sector 55 completes while requested sectors remain, the run stops and errFlags bit 5 (0x0020) is set. When 55 is the last requested sector, the bit stays clear.
- R8: On completion the block writes control offset 2 with the last completed sector shifted left by 2, then offset 3 with (count minus sectors completed) modulo 256. A full run therefore leaves 0xFF.
- R9: In a scan, the first differing byte of a sector decides the result: 1 when the media byte is lower, 3 when it is higher, and 0 when the whole sector is equal. An equal sector sets found. The run ends after the first sector whose result equals scanCond.
- R10: On each port a request holds its valid, address, direction and write data until ready is seen. The memory port and the sector port never request in the same cycle.
- R11: After reset, and whenever idle, the block requests nothing. A start clears errFlags and found. done is a one-cycle pulse in the cycle after the last write-back handshake, and busy drops in the cycle after done.
- R12: A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a command (accepted only when idle) |
| opSel | input | 2 | Operation: 0 read, 1 verify, 2 write, 3 scan |
| scanCond | input | 2 | Scan result that ends the run early |
| ctlAddr | input | 16 | Memory address of the control block |
| dataAddrIn | input | 16 | Starting data address |
| armCyl | input | 8 | Cylinder the arm is on |
| memValid | output | 1 | Memory request |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write byte |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 8 | Memory read byte, valid with memReady |
| secValid | output | 1 | Sector storage request |
| secWrite | output | 1 | Sector request is a write |
| secAddr | output | SEC_AW | Sector storage byte address |
| secWdata | output | 8 | Sector write byte |
| secReady | input | 1 | Sector storage accepts the request this cycle |
| secRdata | input | 8 | Sector read byte, valid with secReady |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlags | output | 16 | Error bits: 11 cylinder (read side), 10 cylinder (write), 5 end of cylinder |
| found | output | 1 | A scan found an equal sector |
| dataAddr | output | 16 | Current data address |

## Verification
The checks take for granted that armCyl does not change while a command runs, that the starting sector lies in 0..23 or 32..55, and that the control block and the data area do not overlap. The stimulus sets armCyl before each start and holds it until done. Its starting sectors come only from the valid ranges, and it keeps control blocks and data areas in separate parts of the bench memory. The ready inputs stall in a fixed pseudo-random pattern, so every request is held across waiting cycles.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_VERIFY = 2'd1,
    OP_WRITE  = 2'd2,
    OP_SCAN   = 2'd3
  } xferOp_e;

  typedef enum logic [1:0] {
    MA_CTL,
    MA_DATA,
    MA_WB_SECT,
    MA_WB_CNT
  } memSel_e;

  localparam int SECTS_PER_CYL = 48;
  localparam logic [5:0] HEAD0_LAST = 6'd23;
  localparam logic [5:0] HEAD1_FIRST = 6'd32;
  localparam logic [5:0] CYL_LAST = 6'd55;
  localparam logic [5:0] HEAD_GAP = HEAD1_FIRST - HEAD0_LAST - 6'd1;

  localparam logic [15:0] ERR_CYL_RD = 16'h0800;
  localparam logic [15:0] ERR_CYL_WR = 16'h0400;
  localparam logic [15:0] ERR_EOC    = 16'h0020;

  typedef struct packed {
    logic    launch;
    logic    ctlCapture;
    logic    secCapture;
    logic    memCapture;
    logic    cmpByte;
    logic    dataInc;
    logic    byteStep;
    logic    sectClose;
    logic    sectStep;
    logic    cylFault;
    logic    eocFault;
    memSel_e memSel;
  } seqStrobe_t;

  function automatic logic [5:0] physIndex(input logic [5:0] logical);
    return (logical > HEAD0_LAST) ? logical - HEAD_GAP : logical;
  endfunction

  function automatic logic [5:0] nextLogical(input logic [5:0] logical);
    return (logical == HEAD0_LAST) ? HEAD1_FIRST : logical + 6'd1;
  endfunction

endpackage

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
  import xfer_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  xferOp_e    op,
  input  logic       memReady,
  input  logic       secReady,
  input  logic       fetchLast,
  input  logic       byteLast,
  input  logic       cylOk,
  input  logic       atCylEnd,
  input  logic       runDone,
  input  logic       scanHit,
  output seqStrobe_t stb,
  output logic       memValid,
  output logic       memWrite,
  output logic       secValid,
  output logic       secWrite,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_SRD, ST_MRD, ST_MWR,
    ST_SWR, ST_CLOSE, ST_WBS, ST_WBC, ST_DONE
  } seqState_e;

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // state to enter after the last handshake of one byte
  seqState_e byteNext;
  always_comb begin
    if (byteLast)             byteNext = ST_CLOSE;
    else if (op == OP_WRITE)  byteNext = ST_MRD;
    else                      byteNext = ST_SRD;
  end

  always_comb begin
    stb        = '0;
    stb.memSel = MA_CTL;
    stateNxt   = state;
    memValid   = 1'b0;
    memWrite   = 1'b0;
    secValid   = 1'b0;
    secWrite   = 1'b0;
    done       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.launch = 1'b1;
          stateNxt   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memValid = 1'b1;
        if (memReady) begin
          stb.ctlCapture = 1'b1;
          if (fetchLast) stateNxt = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!cylOk) begin
          stb.cylFault = 1'b1;
          stateNxt     = ST_WBS;
        end else begin
          stateNxt = (op == OP_WRITE) ? ST_MRD : ST_SRD;
        end
      end
      ST_SRD: begin
        secValid = 1'b1;
        if (secReady) begin
          stb.secCapture = 1'b1;
          if (op == OP_READ)      stateNxt = ST_MWR;
          else if (op == OP_SCAN) stateNxt = ST_MRD;
          else begin
            stb.byteStep = 1'b1;
            stateNxt     = byteNext;
          end
        end
      end
      ST_MRD: begin
        memValid   = 1'b1;
        stb.memSel = MA_DATA;
        if (memReady) begin
          stb.dataInc = 1'b1;
          if (op == OP_WRITE) begin
            stb.memCapture = 1'b1;
            stateNxt       = ST_SWR;
          end else begin
            stb.cmpByte  = 1'b1;
            stb.byteStep = 1'b1;
            stateNxt     = byteNext;
          end
        end
      end
      ST_MWR: begin
        memValid   = 1'b1;
        memWrite   = 1'b1;
        stb.memSel = MA_DATA;
        if (memReady) begin
          stb.dataInc  = 1'b1;
          stb.byteStep = 1'b1;
          stateNxt     = byteNext;
        end
      end
      ST_SWR: begin
        secValid = 1'b1;
        secWrite = 1'b1;
        if (secReady) begin
          stb.byteStep = 1'b1;
          stateNxt     = byteNext;
        end
      end
      ST_CLOSE: begin
        stb.sectClose = 1'b1;
        if ((op == OP_SCAN && scanHit) || runDone) begin
          stateNxt = ST_WBS;
        end else if (atCylEnd) begin
          stb.eocFault = 1'b1;
          stateNxt     = ST_WBS;
        end else begin
          stb.sectStep = 1'b1;
          stateNxt     = ST_CHECK;
        end
      end
      ST_WBS: begin
        memValid   = 1'b1;
        memWrite   = 1'b1;
        stb.memSel = MA_WB_SECT;
        if (memReady) stateNxt = ST_WBC;
      end
      ST_WBC: begin
        memValid   = 1'b1;
        memWrite   = 1'b1;
        stb.memSel = MA_WB_CNT;
        if (memReady) stateNxt = ST_DONE;
      end
      ST_DONE: begin
        done     = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/xfer_seq_dpath.sv
module xfer_seq_dpath
  import xfer_seq_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int SEC_AW     = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [1:0]        opSel,
  input  logic [1:0]        scanCond,
  input  logic [15:0]       ctlAddr,
  input  logic [15:0]       dataAddrIn,
  input  logic [7:0]        armCyl,
  input  logic [7:0]        memRdata,
  input  logic [7:0]        secRdata,
  output xferOp_e           op,
  output logic [15:0]       memAddr,
  output logic [7:0]        memWdata,
  output logic [SEC_AW-1:0] secAddr,
  output logic [7:0]        secWdata,
  output logic              fetchLast,
  output logic              byteLast,
  output logic              cylOk,
  output logic              atCylEnd,
  output logic              runDone,
  output logic              scanHit,
  output logic [15:0]       errFlags,
  output logic              found,
  output logic [15:0]       dataAddr
);

  localparam int BYTE_W    = $clog2(SECT_BYTES);
  localparam int CYL_BYTES = SECTS_PER_CYL * SECT_BYTES;

  logic [1:0]        condReg;
  logic [15:0]       ctlBase;
  logic [7:0]        cylReq;
  logic [7:0]        countReg;
  logic [7:0]        doneCnt;
  logic [5:0]        sectCur;
  logic [5:0]        lastSect;
  logic [1:0]        fetchIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic [7:0]        holdByte;
  logic [1:0]        cmpRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op       <= OP_READ;
      condReg  <= '0;
      ctlBase  <= '0;
      dataAddr <= '0;
      cylReq   <= '0;
      countReg <= '0;
      doneCnt  <= '0;
      sectCur  <= '0;
      lastSect <= '0;
      fetchIdx <= '0;
      byteIdx  <= '0;
      holdByte <= '0;
      cmpRes   <= '0;
      errFlags <= '0;
      found    <= 1'b0;
    end else begin
      if (stb.launch) begin
        op       <= xferOp_e'(opSel);
        condReg  <= scanCond;
        ctlBase  <= ctlAddr;
        dataAddr <= dataAddrIn;
        doneCnt  <= '0;
        fetchIdx <= '0;
        byteIdx  <= '0;
        cmpRes   <= '0;
        errFlags <= '0;
        found    <= 1'b0;
      end
      if (stb.ctlCapture) begin
        fetchIdx <= fetchIdx + 2'd1;
        case (fetchIdx)
          2'd0:    cylReq <= memRdata;
          2'd1: begin
            sectCur  <= memRdata[7:2];
            lastSect <= memRdata[7:2];
          end
          default: countReg <= memRdata;
        endcase
      end
      if (stb.secCapture) holdByte <= secRdata;
      if (stb.memCapture) holdByte <= memRdata;
      if (stb.cmpByte && cmpRes == 2'd0) begin
        if (holdByte < memRdata)      cmpRes <= 2'd1;
        else if (holdByte > memRdata) cmpRes <= 2'd3;
      end
      if (stb.dataInc)  dataAddr <= dataAddr + 16'd1;
      if (stb.byteStep) byteIdx  <= byteIdx + 1'b1;
      if (stb.sectClose) begin
        doneCnt  <= doneCnt + 8'd1;
        lastSect <= sectCur;
        if (op == OP_SCAN && cmpRes == 2'd0) found <= 1'b1;
      end
      if (stb.sectStep) begin
        sectCur <= nextLogical(sectCur);
        cmpRes  <= '0;
      end
      if (stb.cylFault) errFlags <= errFlags | ((op == OP_WRITE) ? ERR_CYL_WR : ERR_CYL_RD);
      if (stb.eocFault) errFlags <= errFlags | ERR_EOC;
    end
  end

  always_comb begin
    case (stb.memSel)
      MA_CTL:     memAddr = ctlBase + 16'd1 + 16'(fetchIdx);
      MA_DATA:    memAddr = dataAddr;
      MA_WB_SECT: memAddr = ctlBase + 16'd2;
      default:    memAddr = ctlBase + 16'd3;
    endcase
    case (stb.memSel)
      MA_WB_SECT: memWdata = {lastSect, 2'b00};
      MA_WB_CNT:  memWdata = countReg - doneCnt;
      default:    memWdata = holdByte;
    endcase
  end

  logic [SEC_AW-1:0] cylBase, sectBase;
  assign cylBase  = SEC_AW'(armCyl) * SEC_AW'(CYL_BYTES);
  assign sectBase = SEC_AW'(physIndex(sectCur)) * SEC_AW'(SECT_BYTES);
  assign secAddr  = cylBase + sectBase + SEC_AW'(byteIdx);
  assign secWdata = holdByte;

  assign fetchLast = (fetchIdx == 2'd2);
  assign byteLast  = (byteIdx == BYTE_W'(SECT_BYTES - 1));
  assign cylOk     = (cylReq == armCyl);
  assign atCylEnd  = (sectCur == CYL_LAST);
  assign runDone   = (doneCnt == countReg);
  assign scanHit   = (cmpRes == condReg);

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  localparam int SEC_AW = $clog2(SECT_BYTES * SECTS_PER_CYL * 256)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opSel,
  input  logic [1:0]        scanCond,
  input  logic [15:0]       ctlAddr,
  input  logic [15:0]       dataAddrIn,
  input  logic [7:0]        armCyl,
  output logic              memValid,
  output logic              memWrite,
  output logic [15:0]       memAddr,
  output logic [7:0]        memWdata,
  input  logic              memReady,
  input  logic [7:0]        memRdata,
  output logic              secValid,
  output logic              secWrite,
  output logic [SEC_AW-1:0] secAddr,
  output logic [7:0]        secWdata,
  input  logic              secReady,
  input  logic [7:0]        secRdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       errFlags,
  output logic              found,
  output logic [15:0]       dataAddr
);

  seqStrobe_t stb;
  xferOp_e    op;
  logic fetchLast, byteLast, cylOk, atCylEnd, runDone, scanHit;

  xfer_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .memReady(memReady), .secReady(secReady),
    .fetchLast(fetchLast), .byteLast(byteLast), .cylOk(cylOk),
    .atCylEnd(atCylEnd), .runDone(runDone), .scanHit(scanHit),
    .stb(stb), .memValid(memValid), .memWrite(memWrite),
    .secValid(secValid), .secWrite(secWrite), .busy(busy), .done(done)
  );

  xfer_seq_dpath #(.SECT_BYTES(SECT_BYTES), .SEC_AW(SEC_AW)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .opSel(opSel), .scanCond(scanCond), .ctlAddr(ctlAddr),
    .dataAddrIn(dataAddrIn), .armCyl(armCyl),
    .memRdata(memRdata), .secRdata(secRdata), .op(op),
    .memAddr(memAddr), .memWdata(memWdata),
    .secAddr(secAddr), .secWdata(secWdata),
    .fetchLast(fetchLast), .byteLast(byteLast), .cylOk(cylOk),
    .atCylEnd(atCylEnd), .runDone(runDone), .scanHit(scanHit),
    .errFlags(errFlags), .found(found), .dataAddr(dataAddr)
  );

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int SECT_BYTES = 256,
  parameter int SEC_AW     = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        opSel,
  input logic [15:0]       ctlAddr,
  input logic [7:0]        armCyl,
  input logic              memValid,
  input logic              memWrite,
  input logic [15:0]       memAddr,
  input logic [7:0]        memWdata,
  input logic              memReady,
  input logic              secValid,
  input logic              secWrite,
  input logic [SEC_AW-1:0] secAddr,
  input logic              secReady,
  input logic              busy,
  input logic              done,
  input logic              eocErr,
  input logic              cylErr
);

  localparam int CYL_BYTES = 48 * SECT_BYTES;

  logic [1:0]  trkOp;
  logic [15:0] trkCtl;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trkOp  <= '0;
      trkCtl <= '0;
    end else if (start && !busy) begin
      trkOp  <= opSel;
      trkCtl <= ctlAddr;
    end
  end

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memValid && secValid)); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)
                                 && $stable(memWdata))); // R10

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (secValid && !secReady) |=> (secValid && $stable(secAddr) && $stable(secWrite))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memValid && !secValid)); // R11

  AST_SEC_IN_CYL: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> (int'(secAddr) / CYL_BYTES == int'(armCyl))); // R2

  AST_VERIFY_NOWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trkOp == 2'd1 && memValid && memWrite)
      |-> (memAddr == trkCtl + 16'd2 || memAddr == trkCtl + 16'd3)); // R4

  AST_EOC_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && eocErr) |-> !cylErr); // R7

endmodule

bind xfer_seq xfer_seq_chk #(.SECT_BYTES(SECT_BYTES), .SEC_AW(SEC_AW)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .ctlAddr(ctlAddr),
  .armCyl(armCyl), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
  .memWdata(memWdata), .memReady(memReady), .secValid(secValid),
  .secWrite(secWrite), .secAddr(secAddr), .secReady(secReady),
  .busy(busy), .done(done), .eocErr(errFlags[5]), .cylErr(|errFlags[11:10])
);

// File: tb/xfer_seq_test.sv
module xfer_seq_test;

  localparam int SB = 4;
  localparam int AW = $clog2(SB * 48 * 256);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] opSel = '0, scanCond = '0;
  logic [15:0] ctlAddr = '0, dataAddrIn = '0;
  logic [7:0] armCyl = '0;
  logic memValid, memWrite, memReady, secValid, secWrite, secReady;
  logic [15:0] memAddr, dataAddr, errFlags;
  logic [7:0] memWdata, memRdata, secWdata, secRdata;
  logic [AW-1:0] secAddr;
  logic busy, done, found;

  xfer_seq #(.SECT_BYTES(SB)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .scanCond(scanCond),
    .ctlAddr(ctlAddr), .dataAddrIn(dataAddrIn), .armCyl(armCyl),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .secValid(secValid), .secWrite(secWrite), .secAddr(secAddr),
    .secWdata(secWdata), .secReady(secReady), .secRdata(secRdata),
    .busy(busy), .done(done), .errFlags(errFlags), .found(found),
    .dataAddr(dataAddr)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] mem [0:4095];
  int secLogA [0:255];
  int secLogD [0:255];
  bit secLogW [0:255];
  int secCnt = 0, memWrCnt = 0, overlapCnt = 0;
  logic [7:0] lfsr = 8'h5B;

  function automatic int sf(input int a);
    return (a * 7 + 3) & 255;
  endfunction
  function automatic int phys(input int s);
    return (s > 23) ? s - 8 : s;
  endfunction
  function automatic int sAddr(input int cyl, input int s, input int k);
    return cyl * 48 * SB + phys(s) * SB + k;
  endfunction

  assign memRdata = mem[memAddr[11:0]];
  assign secRdata = 8'(sf(int'(secAddr)));

  // ready responders change shortly after the active edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memReady = lfsr[0] | lfsr[2];
    secReady = lfsr[1] | lfsr[3];
  end

  // monitor away from the edge: a handshake seen here completes at the next edge
  always @(negedge clk) begin
    cycles++;
    if (memValid && secValid) overlapCnt++;
    if (memValid && memReady && memWrite) begin
      mem[memAddr[11:0]] = memWdata;
      memWrCnt++;
    end
    if (secValid && secReady && secCnt < 256) begin
      secLogA[secCnt] = int'(secAddr);
      secLogD[secCnt] = int'(secWdata);
      secLogW[secCnt] = secWrite;
      secCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  task automatic runXfer(input int op, input int cond, input int ctl, input int da,
                         input int cyl, input int arm, input int sbyte, input int cnt,
                         input bit poke);
    int fullSeq [0:63];
    int nFull, s, nDone, expLast, expErr, tmo, bad;
    bit expFound, stop;
    s = sbyte >> 2;
    nFull = 0;
    for (int i = 0; i < cnt + 1 && i < 64; i++) begin
      fullSeq[i] = s;
      nFull++;
      if (s == 55) break;
      s = (s == 23) ? 32 : s + 1;
    end
    // fill the data area
    for (int i = 0; i < 48; i++)
      for (int k = 0; k < SB; k++) begin
        int a, v;
        a = (da + i * SB + k) & 16'hFFFF;
        if (op == 3 && i < nFull) begin
          v = sf(sAddr(arm, fullSeq[i], k));
          if (k == 1) v = v + ((i % 3 == 1) ? 1 : (i % 3 == 2) ? -1 : 0);
          if (k == 2) v = v + ((i % 3 == 1) ? -1 : (i % 3 == 2) ? 1 : 0);
        end else v = i * 13 + k * 5 + op;
        mem[a[11:0]] = 8'(v);
      end
    mem[ctl[11:0]]       = 8'h5A;
    mem[(ctl + 1) & 4095] = 8'(cyl);
    mem[(ctl + 2) & 4095] = 8'(sbyte);
    mem[(ctl + 3) & 4095] = 8'(cnt);
    // expected outcome
    expErr = 0; expFound = 0; nDone = 0; expLast = sbyte >> 2;
    if (cyl != arm) expErr = (op == 2) ? 16'h0400 : 16'h0800;
    else begin
      stop = 0;
      for (int i = 0; i < nFull && !stop; i++) begin
        nDone++;
        expLast = fullSeq[i];
        if (op == 3) begin
          int res;
          res = 0;
          for (int k = 0; k < SB; k++) begin
            int dsk, mv;
            dsk = sf(sAddr(arm, fullSeq[i], k));
            mv = mem[((da + i * SB + k) & 16'hFFFF) & 4095];
            if (res == 0 && dsk < mv) res = 1;
            else if (res == 0 && dsk > mv) res = 3;
          end
          if (res == 0) expFound = 1;
          if (res == cond) stop = 1;
        end
      end
      if (!stop && nDone < cnt + 1) expErr = 16'h0020;
    end
    secCnt = 0; memWrCnt = 0;
    @(negedge clk);
    opSel = 2'(op); scanCond = 2'(cond); ctlAddr = 16'(ctl);
    dataAddrIn = 16'(da); armCyl = 8'(arm); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      opSel = 2'(op ^ 1); ctlAddr = 16'h0700; dataAddrIn = 16'h0900; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    tmo = 0;
    while (!done && tmo < 20000) begin
      @(negedge clk);
      tmo++;
    end
    chk(done, "R11", "done seen", int'(done), 1);
    chk(errFlags[11:10] == expErr[11:10], "R6", "cylinder error bits",
        int'(errFlags), expErr);
    chk(errFlags[5] == expErr[5], "R7", "end-of-cylinder bit", int'(errFlags), expErr);
    chk(mem[(ctl + 2) & 4095] == 8'(expLast << 2), "R8", "written sector byte",
        int'(mem[(ctl + 2) & 4095]), (expLast << 2) & 255);
    chk(mem[(ctl + 3) & 4095] == 8'(cnt - nDone), "R8", "written count",
        int'(mem[(ctl + 3) & 4095]), (cnt - nDone) & 255);
    chk(secCnt == nDone * SB * ((op == 2) ? 1 : 1), "R1", "sector transfers",
        secCnt, nDone * SB);
    bad = 0;
    for (int i = 0; i < nDone; i++)
      for (int k = 0; k < SB; k++) begin
        int j;
        j = i * SB + k;
        if (j < secCnt && (secLogA[j] != sAddr(arm, fullSeq[i], k)
                           || secLogW[j] != (op == 2))) bad++;
      end
    chk(bad == 0, "R2", "sector address order", bad, 0);
    if (op == 1) begin
      chk(memWrCnt == 2, "R4", "verify memory writes", memWrCnt, 2);
      chk(dataAddr == 16'(da), "R4", "verify data address", int'(dataAddr), da);
    end else begin
      chk(dataAddr == 16'(da + nDone * SB), "R3", "final data address",
          int'(dataAddr), (da + nDone * SB) & 16'hFFFF);
    end
    if (op == 0) begin
      bad = 0;
      for (int i = 0; i < nDone; i++)
        for (int k = 0; k < SB; k++)
          if (mem[((da + i * SB + k) & 16'hFFFF) & 4095]
              != 8'(sf(sAddr(arm, fullSeq[i], k)))) bad++;
      chk(bad == 0, "R3", "read bytes in memory", bad, 0);
      chk(memWrCnt == nDone * SB + 2, "R3", "read memory writes", memWrCnt, nDone * SB + 2);
    end
    if (op == 2) begin
      bad = 0;
      for (int i = 0; i < nDone; i++)
        for (int k = 0; k < SB; k++) begin
          int j;
          j = i * SB + k;
          if (j < secCnt && secLogD[j] != int'(mem[((da + j) & 16'hFFFF) & 4095])) bad++;
        end
      chk(bad == 0, "R5", "written sector bytes", bad, 0);
    end
    if (op == 3) chk(found == expFound, "R9", "found flag", int'(found), int'(expFound));
    if (poke) chk(1'b1, "R12", "start while busy ignored (results above)", 0, 0);
    @(negedge clk);
    chk(!done && !busy, "R11", "done is one cycle", int'({done, busy}), 0);
  endtask

  initial begin
    int starts [0:7];
    int cnts [0:4];
    int conds [0:2];
    int run;
    starts = '{0, 7, 22, 23, 32, 40, 54, 55};
    cnts = '{0, 1, 3, 26, 47};
    conds = '{0, 1, 3};
    memReady = 1'b0; secReady = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memValid && !secValid && errFlags == 0 && !found,
        "R11", "reset state", int'({busy, done, memValid, secValid, found}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memValid && !secValid, "R11", "idle after reset",
        int'({busy, memValid, secValid}), 0);
    run = 0;
    for (int op = 0; op < 4; op++)
      for (int si = 0; si < 8; si++)
        for (int ci = 0; ci < 5; ci++) begin
          runXfer(op, conds[run % 3], 16'h100, 16'h200, (run % 5) + 1, (run % 5) + 1,
                  starts[si] << 2, cnts[ci], 1'b0);
          run++;
        end
    // R6 cylinder mismatch, read and write
    runXfer(0, 0, 16'h140, 16'h300, 4, 6, 10 << 2, 3, 1'b0);
    runXfer(2, 0, 16'h140, 16'h300, 9, 2, 33 << 2, 5, 1'b0);
    runXfer(3, 1, 16'h140, 16'h300, 1, 0, 0, 2, 1'b0);
    // R3 data address wraps modulo 65536
    runXfer(0, 0, 16'h180, 16'hFFFA, 2, 2, 20 << 2, 2, 1'b0);
    // R12 start while busy, both for a long read and a scan
    runXfer(0, 0, 16'h1C0, 16'h400, 3, 3, 5 << 2, 6, 1'b1);
    runXfer(3, 3, 16'h1C0, 16'h400, 3, 3, 30 << 2, 8, 1'b1);
    chk(overlapCnt == 0, "R10", "ports never requested together", overlapCnt, 0);
    finishRun();
  end

endmodule